// File: doc/BRIEF.md
# Block-Copy Bus Slot Sequencer

This block drives the memory-slot schedule of a block-copy engine. Once started, it walks a rectangle of words row by row. On every bus slot it is granted, it issues exactly one action: a read on source channel A, B or C, a write on destination channel D, an idle slot, or the single flush slot that ends the operation. The actions within one word iteration follow a fixed pattern, chosen by a 4-bit channel-enable code. Each pattern includes the idle slots that the bus timing calls for.

The destination write is pipelined. The result of word n is written during the D slot of word n+1, and one trailing flush slot writes the final result. The block keeps one address pointer per channel. Each pointer steps one word per access, in either direction, and has a per-channel modulo applied at the end of every row. The block also presents the mask that the channel A datapath must apply to the current word. Shifting and logic-function datapaths sit outside this block.

Top module: `blit_slot_seq`

## Requirements
- R1: A pulse on `start` while `busy` is low latches the enable code, direction, size, masks, pointers and modulos; `busy` is high from the next cycle. A `start` while `busy` is high has no effect on the slot stream, and input changes after the latching edge are ignored.
- R2: `size_word` bits 5..0 give the row width in words, where 0 means 64. Bits 15..6 give the number of rows, where 0 means 1024. The run issues width×height word iterations, then the flush slot.
- R3: Slot codes on `slot_kind` are 0 idle, 1 read A, 2 read B, 3 read C, 4 write D, 5 flush. In `chan_en`, bit 3 enables A, bit 2 B, bit 1 C and bit 0 D. Each iteration lists the enabled channels in the order A, B, C, D, then pads with idle slots. Codes 0x1, 0x2, 0x3, 0x5, 0x6, 0x7, 0x8 and 0xC add one idle slot. Code 0x4 adds two. Code 0x0 is two idle slots. Codes 0x9, 0xA, 0xB, 0xD, 0xE and 0xF add none.
- R4: The D slot of the first iteration is reported as idle with address 0. The D slot of iteration n ≥ 1 writes to the D address that was current in iteration n−1.
- R5: After the last iteration, one flush slot (code 5) is issued. It carries the last pending D address when D is enabled and address 0 otherwise. `done` is high only during that slot, and `busy` is low from the next cycle.
- R6: Every A, B, C or D slot advances that channel's pointer by +1 in ascending mode, or by −1 when `descend` is set.
- R7: At the end of every row except the last, each enabled channel's pointer has its modulo added in ascending mode, or subtracted in descending mode. Modulos are taken as two's complement.
- R8: During an A read, `a_mask` equals the first-word mask on the first word of a row and the last-word mask on the last word. It is their AND on a one-word row, and all ones otherwise.
- R9: While `slot_en` is low, no slot is issued: `slot_kind` reads 0, `done` stays low and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| chan_en | input | 4 | Channel-enable code: A, B, C, D from bit 3 down |
| descend | input | 1 | Step pointers downward |
| size_word | input | 16 | Height in bits 15..6, width in bits 5..0 |
| first_mask | input | 16 | Channel A mask for the first word of a row |
| last_mask | input | 16 | Channel A mask for the last word of a row |
| ptr_init | input | 4×16 | Start pointers, index 3 = A down to 0 = D |
| mod_init | input | 4×16 | Row-end modulos, same indexing |
| slot_en | input | 1 | A bus slot is granted this cycle |
| slot_kind | output | 3 | Action of the granted slot |
| slot_addr | output | 16 | Word address of the granted slot |
| a_mask | output | 16 | Mask for the current channel A word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Pulse on the flush slot |

## Verification
All sixteen enable codes are run over a 2×2 rectangle, so the per-code slot order, the idle padding and the one-iteration write lag can be told apart. Seeded random runs vary the code, direction, size, masks and modulos together. Slot grants are withheld at random, which separates a sequence that holds from one that skips or repeats. Directed cases cover a one-word row (both masks at once), the zero width and zero height encodings, and a start pulse that arrives mid-run with different settings.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;

    typedef enum logic [2:0] {
        SK_IDLE  = 3'd0,
        SK_RD_A  = 3'd1,
        SK_RD_B  = 3'd2,
        SK_RD_C  = 3'd3,
        SK_WR_D  = 3'd4,
        SK_FLUSH = 3'd5
    } slot_kind_e;

    // one word iteration: up to four slots
    typedef struct packed {
        logic [2:0] len;
        slot_kind_e k0;
        slot_kind_e k1;
        slot_kind_e k2;
        slot_kind_e k3;
    } slot_pat_t;

    function automatic slot_pat_t mk_pat(input logic [2:0] n, input slot_kind_e a,
                                         input slot_kind_e b, input slot_kind_e c,
                                         input slot_kind_e d);
        slot_pat_t p;
        p.len = n;
        p.k0  = a;
        p.k1  = b;
        p.k2  = c;
        p.k3  = d;
        return p;
    endfunction

    // per-code slot pattern, enable bits A=3 B=2 C=1 D=0
    function automatic slot_pat_t pat_of(input logic [3:0] code);
        slot_pat_t p;
        unique case (code)
            4'h0: p = mk_pat(3'd2, SK_IDLE, SK_IDLE, SK_IDLE, SK_IDLE);
            4'h1: p = mk_pat(3'd2, SK_WR_D, SK_IDLE, SK_IDLE, SK_IDLE);
            4'h2: p = mk_pat(3'd2, SK_RD_C, SK_IDLE, SK_IDLE, SK_IDLE);
            4'h3: p = mk_pat(3'd3, SK_RD_C, SK_WR_D, SK_IDLE, SK_IDLE);
            4'h4: p = mk_pat(3'd3, SK_RD_B, SK_IDLE, SK_IDLE, SK_IDLE);
            4'h5: p = mk_pat(3'd3, SK_RD_B, SK_WR_D, SK_IDLE, SK_IDLE);
            4'h6: p = mk_pat(3'd3, SK_RD_B, SK_RD_C, SK_IDLE, SK_IDLE);
            4'h7: p = mk_pat(3'd4, SK_RD_B, SK_RD_C, SK_WR_D, SK_IDLE);
            4'h8: p = mk_pat(3'd2, SK_RD_A, SK_IDLE, SK_IDLE, SK_IDLE);
            4'h9: p = mk_pat(3'd2, SK_RD_A, SK_WR_D, SK_IDLE, SK_IDLE);
            4'hA: p = mk_pat(3'd2, SK_RD_A, SK_RD_C, SK_IDLE, SK_IDLE);
            4'hB: p = mk_pat(3'd3, SK_RD_A, SK_RD_C, SK_WR_D, SK_IDLE);
            4'hC: p = mk_pat(3'd3, SK_RD_A, SK_RD_B, SK_IDLE, SK_IDLE);
            4'hD: p = mk_pat(3'd3, SK_RD_A, SK_RD_B, SK_WR_D, SK_IDLE);
            4'hE: p = mk_pat(3'd3, SK_RD_A, SK_RD_B, SK_RD_C, SK_IDLE);
            default: p = mk_pat(3'd4, SK_RD_A, SK_RD_B, SK_RD_C, SK_WR_D);
        endcase
        return p;
    endfunction

    function automatic slot_kind_e kind_at(input slot_pat_t p, input logic [1:0] idx);
        slot_kind_e k;
        unique case (idx)
            2'd0: k = p.k0;
            2'd1: k = p.k1;
            2'd2: k = p.k2;
            default: k = p.k3;
        endcase
        return k;
    endfunction

    // slot kind that touches the pointer at a given enable-bit index
    function automatic slot_kind_e chan_kind(input int idx);
        slot_kind_e k;
        case (idx)
            3: k = SK_RD_A;
            2: k = SK_RD_B;
            1: k = SK_RD_C;
            default: k = SK_WR_D;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/blit_size_decode.sv
module blit_size_decode #(
    parameter int WF = 6,
    parameter int HF = 10,
    localparam int WW = WF + 1,
    localparam int HW = HF + 1
) (
    input  logic [WF+HF-1:0] size_word,
    output logic [WW-1:0]    width,
    output logic [HW-1:0]    height
);
    logic [WF-1:0] wfield;
    logic [HF-1:0] hfield;

    assign wfield = size_word[WF-1:0];
    assign hfield = size_word[WF+HF-1:WF];

    // an all-zero field selects the largest count
    assign width  = (wfield == '0) ? WW'(1 << WF) : {1'b0, wfield};
    assign height = (hfield == '0) ? HW'(1 << HF) : {1'b0, hfield};
endmodule

// File: rtl/blit_walk.sv
module blit_walk
    import blit_seq_pkg::*;
#(
    parameter int WW = 7,
    parameter int HW = 11,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    input  slot_pat_t     pat,
    input  logic [WW-1:0] width,
    input  logic [HW-1:0] height,
    input  logic [MW-1:0] first_mask,
    input  logic [MW-1:0] last_mask,
    output slot_kind_e    kind,
    output logic          row_end,
    output logic          blit_last,
    output logic [MW-1:0] a_mask
);
    logic [1:0]    step;
    logic [WW-1:0] col;
    logic [HW-1:0] row;
    logic          flushing;
    logic          last_step, last_col, last_row;

    assign last_step = ({1'b0, step} == (pat.len - 3'd1));
    assign last_col  = (col == (width - WW'(1)));
    assign last_row  = (row == (height - HW'(1)));
    assign row_end   = !flushing && last_step && last_col;
    assign blit_last = row_end && last_row;

    assign kind = flushing ? SK_FLUSH : kind_at(pat, step);

    always_comb begin
        a_mask = '1;
        if (col == '0) a_mask = a_mask & first_mask;
        if (last_col)  a_mask = a_mask & last_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= '0;
            col      <= '0;
            row      <= '0;
            flushing <= 1'b0;
        end else if (load) begin
            step     <= '0;
            col      <= '0;
            row      <= '0;
            flushing <= 1'b0;
        end else if (advance) begin
            if (flushing) begin
                flushing <= 1'b0;
            end else if (last_step) begin
                step <= '0;
                if (last_col) begin
                    col <= '0;
                    if (last_row) flushing <= 1'b1;
                    else          row      <= row + HW'(1);
                end else begin
                    col <= col + WW'(1);
                end
            end else begin
                step <= step + 2'd1;
            end
        end
    end
endmodule

// File: rtl/blit_addr_unit.sv
module blit_addr_unit
    import blit_seq_pkg::*;
#(
    parameter int AW = 16,
    localparam int NCH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [NCH-1:0][AW-1:0]  ptr_init,
    input  logic [NCH-1:0][AW-1:0]  mod_init,
    input  logic [NCH-1:0]          en,
    input  logic                    descend,
    input  logic                    issue,
    input  slot_kind_e              kind,
    input  logic                    row_end,
    input  logic                    blit_last,
    output logic [AW-1:0]           addr,
    output logic                    pend_valid
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] ptr [NCH];
    logic [AW-1:0] pend_addr;
    logic [AW-1:0] stride;
    logic          wrap_row;

    assign stride   = descend ? '1 : ONE;
    assign wrap_row = issue && row_end && !blit_last;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [AW-1:0] mod_q;
        logic [AW-1:0] mod_step;
        logic          hit;

        assign hit      = issue && (kind == chan_kind(g));
        assign mod_step = descend ? (~mod_q + ONE) : mod_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr[g] <= '0;
                mod_q  <= '0;
            end else if (load) begin
                ptr[g] <= ptr_init[g];
                mod_q  <= mod_init[g];
            end else begin
                ptr[g] <= ptr[g] + (hit ? stride : '0)
                                 + ((wrap_row && en[g]) ? mod_step : '0);
            end
        end
    end

    // destination address is held back one iteration
    always_ff @(posedge clk) begin
        if (rst || load) begin
            pend_addr  <= '0;
            pend_valid <= 1'b0;
        end else if (issue && kind == SK_WR_D) begin
            pend_addr  <= ptr[0];
            pend_valid <= 1'b1;
        end
    end

    always_comb begin
        unique case (kind)
            SK_RD_A:  addr = ptr[3];
            SK_RD_B:  addr = ptr[2];
            SK_RD_C:  addr = ptr[1];
            SK_WR_D:  addr = pend_addr;
            SK_FLUSH: addr = en[0] ? pend_addr : '0;
            default:  addr = '0;
        endcase
    end
endmodule

// File: rtl/blit_slot_seq.sv
module blit_slot_seq
    import blit_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int MW = 16,
    parameter int WF = 6,
    parameter int HF = 10,
    localparam int WW = WF + 1,
    localparam int HW = HF + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [3:0]           chan_en,
    input  logic                 descend,
    input  logic [WF+HF-1:0]     size_word,
    input  logic [MW-1:0]        first_mask,
    input  logic [MW-1:0]        last_mask,
    input  logic [3:0][AW-1:0]   ptr_init,
    input  logic [3:0][AW-1:0]   mod_init,
    input  logic                 slot_en,
    output logic [2:0]           slot_kind,
    output logic [AW-1:0]        slot_addr,
    output logic [MW-1:0]        a_mask,
    output logic                 busy,
    output logic                 done
);
    logic [3:0]    cfg_en;
    logic          cfg_desc;
    logic [MW-1:0] cfg_first, cfg_last;
    logic [WW-1:0] width_d, width_q;
    logic [HW-1:0] height_d, height_q;
    slot_pat_t     pat;
    slot_kind_e    raw_kind, eff_kind;
    logic          load, issue, row_end, blit_last, pend_valid;
    logic [AW-1:0] addr;

    assign load  = start && !busy;
    assign issue = busy && slot_en;
    assign pat   = pat_of(cfg_en);

    blit_size_decode #(.WF(WF), .HF(HF)) u_size (
        .size_word (size_word),
        .width     (width_d),
        .height    (height_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_en    <= '0;
            cfg_desc  <= 1'b0;
            cfg_first <= '0;
            cfg_last  <= '0;
            width_q   <= WW'(1);
            height_q  <= HW'(1);
        end else if (load) begin
            cfg_en    <= chan_en;
            cfg_desc  <= descend;
            cfg_first <= first_mask;
            cfg_last  <= last_mask;
            width_q   <= width_d;
            height_q  <= height_d;
        end
    end

    blit_walk #(.WW(WW), .HW(HW), .MW(MW)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .advance    (issue),
        .pat        (pat),
        .width      (width_q),
        .height     (height_q),
        .first_mask (cfg_first),
        .last_mask  (cfg_last),
        .kind       (raw_kind),
        .row_end    (row_end),
        .blit_last  (blit_last),
        .a_mask     (a_mask)
    );

    blit_addr_unit #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .ptr_init   (ptr_init),
        .mod_init   (mod_init),
        .en         (cfg_en),
        .descend    (cfg_desc),
        .issue      (issue),
        .kind       (raw_kind),
        .row_end    (row_end),
        .blit_last  (blit_last),
        .addr       (addr),
        .pend_valid (pend_valid)
    );

    // a destination slot with nothing pending stays silent
    assign eff_kind  = (raw_kind == SK_WR_D && !pend_valid) ? SK_IDLE : raw_kind;
    assign slot_kind = issue ? eff_kind : SK_IDLE;
    assign slot_addr = (issue && eff_kind != SK_IDLE) ? addr : '0;
    assign done      = issue && (raw_kind == SK_FLUSH);

    always_ff @(posedge clk) begin
        if (rst)       busy <= 1'b0;
        else if (load) busy <= 1'b1;
        else if (done) busy <= 1'b0;
    end
endmodule

// File: rtl/blit_slot_seq_chk.sv
module blit_slot_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       slot_en,
    input logic [2:0] slot_kind,
    input logic       busy,
    input logic       done
);
    p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!done && slot_kind == 3'd0));

    p_done_flush_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (slot_kind == 3'd5));

    p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_no_grant_r9: assert property (@(posedge clk) disable iff (rst)
        !slot_en |-> (slot_kind == 3'd0 && !done));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !slot_en) |=> busy);
endmodule

bind blit_slot_seq blit_slot_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .slot_en   (slot_en),
    .slot_kind (slot_kind),
    .busy      (busy),
    .done      (done)
);

// File: tb/blit_slot_seq_bench.sv
module blit_slot_seq_bench;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [3:0]      chan_en = '0;
    logic            descend = 1'b0;
    logic [15:0]     size_word = '0;
    logic [15:0]     first_mask = '0, last_mask = '0;
    logic [3:0][15:0] ptr_init = '0, mod_init = '0;
    logic            slot_en = 1'b0;
    logic [2:0]      slot_kind;
    logic [15:0]     slot_addr, a_mask;
    logic            busy, done;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    bit poke = 0;
    int slot_no = 0;

    always #2 clk = ~clk;

    blit_slot_seq u_blit_slot_seq (
        .clk(clk), .rst(rst), .start(start), .chan_en(chan_en), .descend(descend),
        .size_word(size_word), .first_mask(first_mask), .last_mask(last_mask),
        .ptr_init(ptr_init), .mod_init(mod_init), .slot_en(slot_en),
        .slot_kind(slot_kind), .slot_addr(slot_addr), .a_mask(a_mask),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic scramble();
        chan_en    = 4'($urandom);
        descend    = 1'($urandom);
        size_word  = 16'($urandom);
        first_mask = 16'($urandom);
        last_mask  = 16'($urandom);
        for (int c = 0; c < 4; c++) begin
            ptr_init[c] = 16'($urandom);
            mod_init[c] = 16'($urandom);
        end
    endtask

    task automatic expect_slot(input int k, input logic [15:0] a, input bit mchk,
                               input logic [15:0] m, input bit fl);
        bit got = 0;
        while (!got) begin
            @(negedge clk);
            start   = 1'b0;
            slot_en = ($urandom_range(3) != 0);
            if (poke && slot_no == 2) begin
                start = 1'b1;   // R1: must be ignored while busy
                scramble();
            end
            #1;
            if (!slot_en) begin
                chk(slot_kind == 3'd0 && !done, "R9 no grant", {29'd0, slot_kind}, 0);
            end else begin
                got = 1;
                slot_no++;
                chk(slot_kind == 3'(k), "R3 slot kind", {29'd0, slot_kind}, k);
                chk(slot_addr == a, "R6/R7 slot addr", {16'd0, slot_addr}, {16'd0, a});
                if (mchk) chk(a_mask == m, "R8 A mask", {16'd0, a_mask}, {16'd0, m});
                chk(done == fl, "R5 done pulse", {31'd0, done}, {31'd0, fl});
            end
        end
    endtask

    task automatic run_blit(input logic [3:0] code, input bit desc, input logic [15:0] sz,
                            input logic [15:0] fm, input logic [15:0] lm);
        int w, h, plen, pad;
        int pk[4];
        logic [15:0] p[4];
        logic [15:0] md[4];
        logic [15:0] dir, pa, m, ea;
        bit pv;
        int ek;
        w = (sz[5:0] == 0) ? 64 : int'(sz[5:0]);
        h = (sz[15:6] == 0) ? 1024 : int'(sz[15:6]);
        plen = 0;
        for (int c = 3; c >= 0; c--) if (code[c]) begin
            pk[plen] = (c == 0) ? 4 : 4 - c;
            plen++;
        end
        if (code == 4'h0 || code == 4'h4) pad = 2;
        else if (code inside {4'h1, 4'h2, 4'h3, 4'h5, 4'h6, 4'h7, 4'h8, 4'hC}) pad = 1;
        else pad = 0;
        for (int i = 0; i < pad; i++) begin pk[plen] = 0; plen++; end
        for (int c = 0; c < 4; c++) begin p[c] = ptr_init[c]; md[c] = mod_init[c]; end
        dir = desc ? 16'hFFFF : 16'h0001;
        pv = 0; pa = '0; slot_no = 0;

        @(negedge clk);
        chan_en = code; descend = desc; size_word = sz;
        first_mask = fm; last_mask = lm; start = 1'b1; slot_en = 1'b0;
        #1 chk(!busy, "R1 idle before start", {31'd0, busy}, 0);
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1 busy after start", {31'd0, busy}, 1);
        scramble();   // R1: later input changes are not used

        for (int yy = 0; yy < h; yy++) begin
            for (int xx = 0; xx < w; xx++) begin
                m = ((xx == 0) ? fm : 16'hFFFF) & ((xx == w - 1) ? lm : 16'hFFFF);
                for (int s = 0; s < plen; s++) begin
                    ek = pk[s]; ea = '0;
                    case (pk[s])
                        1: begin ea = p[3]; p[3] = p[3] + dir; end
                        2: begin ea = p[2]; p[2] = p[2] + dir; end
                        3: begin ea = p[1]; p[1] = p[1] + dir; end
                        4: begin   // R4 deferred write
                            if (pv) ea = pa; else ek = 0;
                            pa = p[0]; pv = 1; p[0] = p[0] + dir;
                        end
                        default: ;
                    endcase
                    expect_slot(ek, ea, pk[s] == 1, m, 0);
                end
                if (xx == w - 1 && yy != h - 1)
                    for (int c = 0; c < 4; c++)
                        if (code[c]) p[c] = desc ? p[c] - md[c] : p[c] + md[c];
            end
        end
        expect_slot(5, code[0] ? pa : 16'h0, 0, '0, 1);   // R5 flush
        @(negedge clk);
        slot_en = 1'b0;
        chk(!busy, "R5 busy low after flush", {31'd0, busy}, 0);
    endtask

    task automatic set_ptrs();
        for (int c = 0; c < 4; c++) begin
            ptr_init[c] = 16'h1000 * 16'(c + 1);
            mod_init[c] = 16'(3 + c);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!busy && !done && slot_kind == 3'd0, "R1 reset state", {28'd0, busy, slot_kind}, 0);

        // R3/R4: every enable code over a 2x2 rectangle
        for (int code = 0; code < 16; code++) begin
            set_ptrs();
            run_blit(4'(code), 0, {10'd2, 6'd2}, 16'hFF00, 16'h00FF);
        end
        // R6/R7 descending
        set_ptrs();
        run_blit(4'hF, 1, {10'd3, 6'd3}, 16'h0FFF, 16'hFFF0);
        // R8 one-word rows
        set_ptrs();
        run_blit(4'h9, 0, {10'd3, 6'd1}, 16'h7FF0, 16'h0FFE);
        // R2 zero width means 64
        set_ptrs();
        run_blit(4'hB, 0, {10'd1, 6'd0}, 16'h00FF, 16'hF000);
        // R2 zero height means 1024
        set_ptrs();
        run_blit(4'h8, 0, {10'd0, 6'd1}, 16'hFFFF, 16'hFFFF);
        // R1 start while busy
        set_ptrs();
        poke = 1;
        run_blit(4'hD, 0, {10'd2, 6'd3}, 16'h1234, 16'h8765);
        poke = 0;
        // random mix
        for (int t = 0; t < 40; t++) begin
            for (int c = 0; c < 4; c++) begin
                ptr_init[c] = 16'($urandom);
                mod_init[c] = 16'($urandom_range(20)) - 16'd10;
            end
            run_blit(4'($urandom), 1'($urandom),
                     {10'($urandom_range(3, 1)), 6'($urandom_range(5, 1))},
                     16'($urandom), 16'($urandom));
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule